// File: doc/BRIEF.md
# Compelled Signalling Sequencer

This block decides, channel by channel, when the local multifrequency transmitter of a register-signalling link is sounding and which pair of frequencies it sends. It takes a per-channel configuration (enable, sending direction, automatic or manual handshake, end-of-tone reporting), a shared data-format bit, transmit commands from the host, and the status of each channel's tone detector. From these it drives a tone-on flag and a six-bit frequency mask to each transmitter, and raises one-cycle report pulses toward the host when a far-end tone appears or goes away.

In manual operation the host alone switches the transmitter on and off. In automatic operation each channel runs a two-state handshake: a quiet state (no far-end tone heard) and a heard state (far-end tone present). A channel that sends forward signals may transmit only while quiet; a channel that sends backward signals may transmit only while it hears the far end. A command issued while transmission is forbidden is parked and fires on the cycle the channel enters the state that permits transmission, and entering the forbidden state silences the transmitter at once.

The frequency mask uses one bit per frequency, bit 0 for the lowest frequency of the group up to bit 5 for the highest. Commands and reports use either this six-bit mask directly or a four-bit pair index, chosen by the format bit.

Top module: `r2seq_top`

## Requirements
- R1: After reset every channel is disabled (fields reset to enable 0, end-of-tone 1, manual handshake, forward direction, mask format); all tx_on, tx_mask, rpt_tone, rpt_end and rpt_code outputs are 0, and a command to a channel before it is configured leaves its transmitter off.
- R2: In manual handshake (cfg_data bit 1 = 0) a command to an enabled channel sets tx_on and tx_mask on the clock edge that samples it, whatever the detector shows; a command decoding to no valid pair turns the transmitter off. While tx_on is 1 the mask has exactly two bits set, and while it is 0 the mask is 0.
- R3: In pair-index format (cfg_data bit 4 = 1) cmd_code[3:0] = n selects the pair with high bit h and low bit l (h > l) where n = h(h-1)/2 + l + 1, counting h and l from 0; n = 0 means tone off and cmd_code[5:4] are ignored. In mask format (bit 4 = 0) a code with exactly two bits set is used as the mask and any other code means tone off.
- R4: In automatic forward operation (cfg_data bits 1 and 0 = 1) a command in the quiet state takes effect on the same edge, and the edge that enters the heard state turns the transmitter off.
- R5: In automatic backward operation (bit 1 = 1, bit 0 = 0) the transmitter is held off in the quiet state, a command in the heard state takes effect on the same edge, and the edge that returns to quiet turns it off.
- R6: In automatic operation a command sampled in the forbidden state leaves the transmitter off and is held; on the edge that enters the permitted state the transmitter turns on with the held mask.
- R7: A later command replaces a held one; a held command that decodes to tone off empties the slot so that entering the permitted state starts nothing.
- R8: The edge on which an enabled channel goes from quiet to heard raises rpt_tone for one cycle with rpt_code set to the detected mask in mask format, or to {2'b00, pair index} in pair-index format; rpt_code is 0 in every other cycle.
- R9: The edge on which an enabled channel goes from heard to quiet raises rpt_end for one cycle if end-of-tone reporting (cfg_data bit 2) is 1, and raises nothing if it is 0.
- R10: A disabled channel (cfg_data bit 3 = 0) keeps its state, reports nothing and ignores commands, and disabling it leaves a sounding tone unchanged.
- R11: cmd_ch and cfg_ch select one channel; commands and configuration writes leave the other channels untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_ch | input | 1 | Channel written by cfg_wr |
| cfg_data | input | 5 | bit 0 forward, bit 1 automatic, bit 2 end-of-tone report, bit 3 enable, bit 4 pair-index format (shared) |
| cmd_wr | input | 1 | Transmit command strobe |
| cmd_ch | input | 1 | Channel addressed by the command |
| cmd_code | input | 6 | Tone code of the command |
| det_on | input | 2 | Per channel: far-end tone present |
| det_mask | input | 12 | Per channel six-bit detected frequency mask, channel 0 in the low bits |
| tx_on | output | 2 | Per channel: transmitter sounding |
| tx_mask | output | 12 | Per channel six-bit frequency mask sent, channel 0 in the low bits |
| rpt_tone | output | 2 | Per channel one-cycle pulse: far-end tone received |
| rpt_end | output | 2 | Per channel one-cycle pulse: far-end tone ended |
| rpt_code | output | 12 | Per channel received code, valid with rpt_tone |

## Verification
The assertions watch every cycle that a transmitter is never sounding in the forbidden state of the automatic handshake, that a sounding mask always carries exactly one frequency pair, that held commands are valid pairs, and that a disabled channel neither moves nor reports while report pulses only coincide with real state changes. What only the bench's scenarios can show is the sequencing itself: that a held command fires on the right edge with the right mask, that a newer or tone-off command replaces it, that the two pair formats decode and report the correct values, and that channels stay independent.

// File: rtl/r2seq_pkg.sv
package r2seq_pkg;

    localparam int TONE_W  = 6;
    localparam int INDEX_W = 4;
    localparam int NPAIRS  = (TONE_W * (TONE_W - 1)) / 2;
    localparam int CFG_W   = 5;
    localparam int FMT_BIT = 4;

    typedef enum logic {
        LINK_QUIET = 1'b0,
        LINK_HEARD = 1'b1
    } link_t;

    // Field order matches cfg_data[3:0]
    typedef struct packed {
        logic en;
        logic eod;
        logic auto_m;
        logic fwd;
    } chan_cfg_t;

    localparam chan_cfg_t CFG_RESET = '{en: 1'b0, eod: 1'b1, auto_m: 1'b0, fwd: 1'b1};

    // Pair number n (1..NPAIRS) to a two-bit frequency mask; 0 gives 0
    function automatic logic [TONE_W-1:0] pair_of(input logic [INDEX_W-1:0] idx);
        logic [TONE_W-1:0]  m;
        logic [INDEX_W-1:0] n;
        m = '0;
        n = '0;
        for (int h = 1; h < TONE_W; h++) begin
            for (int l = 0; l < h; l++) begin
                n = n + INDEX_W'(1);
                if (n == idx) begin
                    m = (TONE_W'(1) << h) | (TONE_W'(1) << l);
                end
            end
        end
        return m;
    endfunction

    // Mask back to pair number; 0 when it is not a valid pair
    function automatic logic [INDEX_W-1:0] index_of(input logic [TONE_W-1:0] m);
        logic [INDEX_W-1:0] r;
        r = '0;
        for (int i = 1; i <= NPAIRS; i++) begin
            if (pair_of(INDEX_W'(i)) == m) begin
                r = INDEX_W'(i);
            end
        end
        return r;
    endfunction

    function automatic logic [TONE_W-1:0] cmd_to_mask(input logic [TONE_W-1:0] code,
                                                      input logic             bin);
        logic [TONE_W-1:0] m;
        if (bin) begin
            m = pair_of(code[INDEX_W-1:0]);
        end else if ($countones(code) == 2) begin
            m = code;
        end else begin
            m = '0;
        end
        return m;
    endfunction

    function automatic logic [TONE_W-1:0] report_of(input logic [TONE_W-1:0] m,
                                                    input logic             bin);
        return bin ? {{(TONE_W-INDEX_W){1'b0}}, index_of(m)} : m;
    endfunction

    function automatic logic tx_allowed(input chan_cfg_t c, input link_t s);
        logic ok;
        if (!c.auto_m) begin
            ok = 1'b1;
        end else if (c.fwd) begin
            ok = (s == LINK_QUIET);
        end else begin
            ok = (s == LINK_HEARD);
        end
        return ok;
    endfunction

endpackage

// File: rtl/r2seq_cmd_dec.sv
module r2seq_cmd_dec
    import r2seq_pkg::*;
(
    input  logic [TONE_W-1:0] code,
    input  logic              fmt_bin,
    output logic [TONE_W-1:0] mask
);

    always_comb begin
        mask = cmd_to_mask(code, fmt_bin);
    end

endmodule

// File: rtl/r2seq_link.sv
module r2seq_link
    import r2seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  chan_cfg_t         cfg_in,
    input  logic              fmt_bin,
    input  logic              det_on,
    input  logic [TONE_W-1:0] det_mask,
    output chan_cfg_t         cfg_q,
    output chan_cfg_t         cfg_n,
    output link_t             state_q,
    output link_t             state_n,
    output logic              rpt_tone,
    output logic              rpt_end,
    output logic [TONE_W-1:0] rpt_code
);

    logic              tone_d;
    logic              end_d;
    logic [TONE_W-1:0] code_d;

    always_comb begin
        cfg_n   = cfg_wr ? cfg_in : cfg_q;
        state_n = state_q;
        if (cfg_n.en) begin
            state_n = det_on ? LINK_HEARD : LINK_QUIET;
        end
        tone_d = cfg_n.en && (state_q == LINK_QUIET) && det_on;
        end_d  = cfg_n.en && (state_q == LINK_HEARD) && !det_on && cfg_n.eod;
        code_d = tone_d ? report_of(det_mask, fmt_bin) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= CFG_RESET;
            state_q  <= LINK_QUIET;
            rpt_tone <= 1'b0;
            rpt_end  <= 1'b0;
            rpt_code <= '0;
        end else begin
            cfg_q    <= cfg_n;
            state_q  <= state_n;
            rpt_tone <= tone_d;
            rpt_end  <= end_d;
            rpt_code <= code_d;
        end
    end

    // R10
    disabled_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_n.en |=> ($stable(state_q) && !rpt_tone && !rpt_end));

    // R8
    tone_entry_chk: assert property (@(posedge clk) disable iff (rst)
        rpt_tone |-> (state_q == LINK_HEARD && $past(state_q) == LINK_QUIET));

    // R9
    end_entry_chk: assert property (@(posedge clk) disable iff (rst)
        rpt_end |-> (state_q == LINK_QUIET && $past(state_q) == LINK_HEARD && cfg_q.eod));

    // R8
    code_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !rpt_tone |-> (rpt_code == '0));

endmodule

// File: rtl/r2seq_txctl.sv
module r2seq_txctl
    import r2seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  chan_cfg_t         cfg_q,
    input  chan_cfg_t         cfg_n,
    input  link_t             state_q,
    input  link_t             state_n,
    input  logic              cmd_hit,
    input  logic [TONE_W-1:0] cmd_mask,
    output logic              tx_on,
    output logic [TONE_W-1:0] tx_mask
);

    logic              pend_v_q, pend_v_d;
    logic [TONE_W-1:0] pend_m_q, pend_m_d;
    logic              on_d;
    logic [TONE_W-1:0] mask_d;
    logic              perm_now, perm_next;

    always_comb begin
        perm_now  = tx_allowed(cfg_n, state_q);
        perm_next = tx_allowed(cfg_n, state_n);
        on_d      = tx_on;
        mask_d    = tx_mask;
        pend_v_d  = pend_v_q;
        pend_m_d  = pend_m_q;
        if (cfg_n.en) begin
            if (!cfg_n.auto_m) begin
                pend_v_d = 1'b0;
                pend_m_d = '0;
                if (cmd_hit) begin
                    on_d   = |cmd_mask;
                    mask_d = cmd_mask;
                end
            end else begin
                if (cmd_hit) begin
                    if (perm_next) begin
                        on_d     = |cmd_mask;
                        mask_d   = cmd_mask;
                        pend_v_d = 1'b0;
                        pend_m_d = '0;
                    end else begin
                        pend_v_d = |cmd_mask;
                        pend_m_d = cmd_mask;
                    end
                end else if (perm_next && !perm_now && pend_v_q) begin
                    on_d     = 1'b1;
                    mask_d   = pend_m_q;
                    pend_v_d = 1'b0;
                    pend_m_d = '0;
                end
                if (!perm_next) begin
                    on_d   = 1'b0;
                    mask_d = '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_on    <= 1'b0;
            tx_mask  <= '0;
            pend_v_q <= 1'b0;
            pend_m_q <= '0;
        end else begin
            tx_on    <= on_d;
            tx_mask  <= mask_d;
            pend_v_q <= pend_v_d;
            pend_m_q <= pend_m_d;
        end
    end

    // R4 R5
    forbid_silent_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.en && cfg_q.auto_m && !tx_allowed(cfg_q, state_q)) |-> !tx_on);

    // R2
    pair_on_chk: assert property (@(posedge clk) disable iff (rst)
        tx_on |-> ($countones(tx_mask) == 2));

    // R2
    mask_off_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_on |-> (tx_mask == '0));

    // R7
    held_pair_chk: assert property (@(posedge clk) disable iff (rst)
        pend_v_q |-> ($countones(pend_m_q) == 2));

endmodule

// File: rtl/r2seq_top.sv
module r2seq_top
    import r2seq_pkg::*;
#(
    parameter  int NUM_CH = 2,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cfg_wr,
    input  logic [CH_W-1:0]          cfg_ch,
    input  logic [CFG_W-1:0]         cfg_data,
    input  logic                     cmd_wr,
    input  logic [CH_W-1:0]          cmd_ch,
    input  logic [TONE_W-1:0]        cmd_code,
    input  logic [NUM_CH-1:0]        det_on,
    input  logic [NUM_CH*TONE_W-1:0] det_mask,
    output logic [NUM_CH-1:0]        tx_on,
    output logic [NUM_CH*TONE_W-1:0] tx_mask,
    output logic [NUM_CH-1:0]        rpt_tone,
    output logic [NUM_CH-1:0]        rpt_end,
    output logic [NUM_CH*TONE_W-1:0] rpt_code
);

    logic              fmt_q;
    logic              fmt_n;
    logic [TONE_W-1:0] cmd_mask;
    chan_cfg_t         cfg_word;

    assign fmt_n    = cfg_wr ? cfg_data[FMT_BIT] : fmt_q;
    assign cfg_word = chan_cfg_t'(cfg_data[3:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            fmt_q <= 1'b0;
        end else begin
            fmt_q <= fmt_n;
        end
    end

    r2seq_cmd_dec u_dec (
        .code    (cmd_code),
        .fmt_bin (fmt_n),
        .mask    (cmd_mask)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        chan_cfg_t cfg_q;
        chan_cfg_t cfg_n;
        link_t     state_q;
        link_t     state_n;
        logic      sel_cfg;
        logic      sel_cmd;

        assign sel_cfg = cfg_wr && (cfg_ch == CH_W'(g));
        assign sel_cmd = cmd_wr && (cmd_ch == CH_W'(g));

        r2seq_link u_link (
            .clk      (clk),
            .rst      (rst),
            .cfg_wr   (sel_cfg),
            .cfg_in   (cfg_word),
            .fmt_bin  (fmt_n),
            .det_on   (det_on[g]),
            .det_mask (det_mask[g*TONE_W +: TONE_W]),
            .cfg_q    (cfg_q),
            .cfg_n    (cfg_n),
            .state_q  (state_q),
            .state_n  (state_n),
            .rpt_tone (rpt_tone[g]),
            .rpt_end  (rpt_end[g]),
            .rpt_code (rpt_code[g*TONE_W +: TONE_W])
        );

        r2seq_txctl u_tx (
            .clk      (clk),
            .rst      (rst),
            .cfg_q    (cfg_q),
            .cfg_n    (cfg_n),
            .state_q  (state_q),
            .state_n  (state_n),
            .cmd_hit  (sel_cmd),
            .cmd_mask (cmd_mask),
            .tx_on    (tx_on[g]),
            .tx_mask  (tx_mask[g*TONE_W +: TONE_W])
        );
    end

    // R3
    cmd_pair_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |-> ($countones(cmd_mask) == 0 || $countones(cmd_mask) == 2));

    // R11
    tx_one_ch_chk: assert property (@(posedge clk) disable iff (rst)
        !cmd_wr && !cfg_wr |=> $stable(fmt_q));

endmodule

// File: tb/r2seq_top_tb_top.sv
module r2seq_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [0:0]  cfg_ch = '0;
    logic [4:0]  cfg_data = '0;
    logic        cmd_wr = 1'b0;
    logic [0:0]  cmd_ch = '0;
    logic [5:0]  cmd_code = '0;
    logic [1:0]  det_on = '0;
    logic [11:0] det_mask = '0;
    logic [1:0]  tx_on;
    logic [11:0] tx_mask;
    logic [1:0]  rpt_tone;
    logic [1:0]  rpt_end;
    logic [11:0] rpt_code;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    r2seq_top #(.NUM_CH(2)) dut_i (
        .clk(clk), .rst(rst),
        .cfg_wr(cfg_wr), .cfg_ch(cfg_ch), .cfg_data(cfg_data),
        .cmd_wr(cmd_wr), .cmd_ch(cmd_ch), .cmd_code(cmd_code),
        .det_on(det_on), .det_mask(det_mask),
        .tx_on(tx_on), .tx_mask(tx_mask),
        .rpt_tone(rpt_tone), .rpt_end(rpt_end), .rpt_code(rpt_code)
    );

    typedef struct packed {
        logic [3:0] req;
        logic       cw;  logic cc; logic [4:0] cd;
        logic       mw;  logic mc; logic [5:0] mcode;
        logic [1:0] don; logic [5:0] dm0; logic [5:0] dm1;
        logic [1:0] etx; logic [5:0] em0; logic [5:0] em1;
        logic [1:0] ert; logic [1:0] ere; logic [5:0] ec0; logic [5:0] ec1;
    } vec_t;

    localparam int NV = 38;
    // cfg_data: bit0 forward, bit1 automatic, bit2 end-of-tone, bit3 enable, bit4 pair-index
    localparam vec_t VECS [NV] = '{
        // R1 disabled after reset: command and detector ignored
        '{4'd1, 1'b0,1'b0,5'h00, 1'b1,1'b0,6'h03, 2'b00,6'h00,6'h00, 2'b00,6'h00,6'h00, 2'b00,2'b00,6'h00,6'h00},
        '{4'd1, 1'b0,1'b0,5'h00, 1'b0,1'b0,6'h00, 2'b01,6'h12,6'h00, 2'b00,6'h00,6'h00, 2'b00,2'b00,6'h00,6'h00},
        // R2 manual forward
        '{4'd2, 1'b1,1'b0,5'h0D, 1'b0,1'b0,6'h00, 2'b00,6'h00,6'h00, 2'b00,6'h00,6'h00, 2'b00,2'b00,6'h00,6'h00},
        '{4'd2, 1'b0,1'b0,5'h00, 1'b1,1'b0,6'h05, 2'b00,6'h00,6'h00, 2'b01,6'h05,6'h00, 2'b00,2'b00,6'h00,6'h00},
        // R8 report while manual tone keeps sounding
        '{4'd8, 1'b0,1'b0,5'h00, 1'b0,1'b0,6'h00, 2'b01,6'h12,6'h00, 2'b01,6'h05,6'h00, 2'b01,2'b00,6'h12,6'h00},
        '{4'd2, 1'b0,1'b0,5'h00, 1'b1,1'b0,6'h00, 2'b01,6'h12,6'h00, 2'b00,6'h00,6'h00, 2'b00,2'b00,6'h00,6'h00},
        // R9 end-of-tone reported
        '{4'd9, 1'b0,1'b0,5'h00, 1'b0,1'b0,6'h00, 2'b00,6'h00,6'h00, 2'b00,6'h00,6'h00, 2'b00,2'b01,6'h00,6'h00},
        // R3 three-bit mask code is tone off
        '{4'd3, 1'b0,1'b0,5'h00, 1'b1,1'b0,6'h07, 2'b00,6'h00,6'h00, 2'b00,6'h00,6'h00, 2'b00,2'b00,6'h00,6'h00},
        // R4 automatic forward
        '{4'd4, 1'b1,1'b0,5'h0F, 1'b0,1'b0,6'h00, 2'b00,6'h00,6'h00, 2'b00,6'h00,6'h00, 2'b00,2'b00,6'h00,6'h00},
        '{4'd4, 1'b0,1'b0,5'h00, 1'b1,1'b0,6'h0C, 2'b00,6'h00,6'h00, 2'b01,6'h0C,6'h00, 2'b00,2'b00,6'h00,6'h00},
        '{4'd4, 1'b0,1'b0,5'h00, 1'b0,1'b0,6'h00, 2'b01,6'h30,6'h00, 2'b00,6'h00,6'h00, 2'b01,2'b00,6'h30,6'h00},
        // R6 held in forbidden state
        '{4'd6, 1'b0,1'b0,5'h00, 1'b1,1'b0,6'h21, 2'b01,6'h30,6'h00, 2'b00,6'h00,6'h00, 2'b00,2'b00,6'h00,6'h00},
        // R7 replaced by newer command
        '{4'd7, 1'b0,1'b0,5'h00, 1'b1,1'b0,6'h24, 2'b01,6'h30,6'h00, 2'b00,6'h00,6'h00, 2'b00,2'b00,6'h00,6'h00},
        // R6 fires on entry to quiet
        '{4'd6, 1'b0,1'b0,5'h00, 1'b0,1'b0,6'h00, 2'b00,6'h00,6'h00, 2'b01,6'h24,6'h00, 2'b00,2'b01,6'h00,6'h00},
        '{4'd7, 1'b0,1'b0,5'h00, 1'b1,1'b0,6'h00, 2'b00,6'h00,6'h00, 2'b00,6'h00,6'h00, 2'b00,2'b00,6'h00,6'h00},
        '{4'd7, 1'b0,1'b0,5'h00, 1'b0,1'b0,6'h00, 2'b01,6'h03,6'h00, 2'b00,6'h00,6'h00, 2'b01,2'b00,6'h03,6'h00},
        '{4'd7, 1'b0,1'b0,5'h00, 1'b1,1'b0,6'h06, 2'b01,6'h03,6'h00, 2'b00,6'h00,6'h00, 2'b00,2'b00,6'h00,6'h00},
        // R7 tone-off empties the slot
        '{4'd7, 1'b0,1'b0,5'h00, 1'b1,1'b0,6'h00, 2'b01,6'h03,6'h00, 2'b00,6'h00,6'h00, 2'b00,2'b00,6'h00,6'h00},
        '{4'd7, 1'b0,1'b0,5'h00, 1'b0,1'b0,6'h00, 2'b00,6'h00,6'h00, 2'b00,6'h00,6'h00, 2'b00,2'b01,6'h00,6'h00},
        // R5 automatic backward
        '{4'd5, 1'b1,1'b0,5'h0E, 1'b0,1'b0,6'h00, 2'b00,6'h00,6'h00, 2'b00,6'h00,6'h00, 2'b00,2'b00,6'h00,6'h00},
        '{4'd5, 1'b0,1'b0,5'h00, 1'b1,1'b0,6'h11, 2'b00,6'h00,6'h00, 2'b00,6'h00,6'h00, 2'b00,2'b00,6'h00,6'h00},
        '{4'd5, 1'b0,1'b0,5'h00, 1'b0,1'b0,6'h00, 2'b01,6'h0A,6'h00, 2'b01,6'h11,6'h00, 2'b01,2'b00,6'h0A,6'h00},
        '{4'd5, 1'b0,1'b0,5'h00, 1'b1,1'b0,6'h18, 2'b01,6'h0A,6'h00, 2'b01,6'h18,6'h00, 2'b00,2'b00,6'h00,6'h00},
        '{4'd5, 1'b0,1'b0,5'h00, 1'b0,1'b0,6'h00, 2'b00,6'h00,6'h00, 2'b00,6'h00,6'h00, 2'b00,2'b01,6'h00,6'h00},
        // R3 pair-index format, upper bits ignored: 11 -> 0x21
        '{4'd3, 1'b1,1'b0,5'h1F, 1'b0,1'b0,6'h00, 2'b00,6'h00,6'h00, 2'b00,6'h00,6'h00, 2'b00,2'b00,6'h00,6'h00},
        '{4'd3, 1'b0,1'b0,5'h00, 1'b1,1'b0,6'h3B, 2'b00,6'h00,6'h00, 2'b01,6'h21,6'h00, 2'b00,2'b00,6'h00,6'h00},
        // R8 report in pair-index format: 0x12 -> 8
        '{4'd8, 1'b0,1'b0,5'h00, 1'b0,1'b0,6'h00, 2'b01,6'h12,6'h00, 2'b00,6'h00,6'h00, 2'b01,2'b00,6'h08,6'h00},
        // R9 end-of-tone reporting off
        '{4'd9, 1'b1,1'b0,5'h1B, 1'b0,1'b0,6'h00, 2'b01,6'h12,6'h00, 2'b00,6'h00,6'h00, 2'b00,2'b00,6'h00,6'h00},
        '{4'd9, 1'b0,1'b0,5'h00, 1'b0,1'b0,6'h00, 2'b00,6'h00,6'h00, 2'b00,6'h00,6'h00, 2'b00,2'b00,6'h00,6'h00},
        // R10 disable leaves a tone sounding
        '{4'd10,1'b1,1'b0,5'h0D, 1'b0,1'b0,6'h00, 2'b00,6'h00,6'h00, 2'b00,6'h00,6'h00, 2'b00,2'b00,6'h00,6'h00},
        '{4'd10,1'b0,1'b0,5'h00, 1'b1,1'b0,6'h03, 2'b00,6'h00,6'h00, 2'b01,6'h03,6'h00, 2'b00,2'b00,6'h00,6'h00},
        '{4'd10,1'b1,1'b0,5'h05, 1'b0,1'b0,6'h00, 2'b00,6'h00,6'h00, 2'b01,6'h03,6'h00, 2'b00,2'b00,6'h00,6'h00},
        '{4'd10,1'b0,1'b0,5'h00, 1'b1,1'b0,6'h00, 2'b01,6'h05,6'h00, 2'b01,6'h03,6'h00, 2'b00,2'b00,6'h00,6'h00},
        '{4'd10,1'b0,1'b0,5'h00, 1'b0,1'b0,6'h00, 2'b00,6'h00,6'h00, 2'b01,6'h03,6'h00, 2'b00,2'b00,6'h00,6'h00},
        // R11 second channel independent
        '{4'd11,1'b0,1'b0,5'h00, 1'b1,1'b1,6'h09, 2'b00,6'h00,6'h00, 2'b01,6'h03,6'h00, 2'b00,2'b00,6'h00,6'h00},
        '{4'd11,1'b1,1'b1,5'h0D, 1'b0,1'b0,6'h00, 2'b00,6'h00,6'h00, 2'b01,6'h03,6'h00, 2'b00,2'b00,6'h00,6'h00},
        '{4'd11,1'b0,1'b0,5'h00, 1'b1,1'b1,6'h09, 2'b00,6'h00,6'h00, 2'b11,6'h03,6'h09, 2'b00,2'b00,6'h00,6'h00},
        '{4'd11,1'b0,1'b0,5'h00, 1'b0,1'b0,6'h00, 2'b10,6'h00,6'h14, 2'b11,6'h03,6'h09, 2'b10,2'b00,6'h00,6'h14}
    };

    task automatic drive(input vec_t v);
        cfg_wr   = v.cw;
        cfg_ch   = v.cc;
        cfg_data = v.cd;
        cmd_wr   = v.mw;
        cmd_ch   = v.mc;
        cmd_code = v.mcode;
        det_on   = v.don;
        det_mask = {v.dm1, v.dm0};
    endtask

    task automatic idle_inputs();
        cfg_wr = 1'b0; cfg_ch = '0; cfg_data = '0;
        cmd_wr = 1'b0; cmd_ch = '0; cmd_code = '0;
        det_on = '0;   det_mask = '0;
    endtask

    task automatic compare(input int req, input int idx, input vec_t v);
        logic [39:0] act, exp;
        act = {tx_on, tx_mask, rpt_tone, rpt_end, rpt_code};
        exp = {v.etx, v.em1, v.em0, v.ert, v.ere, v.ec1, v.ec0};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d step %0d: {tx_on,tx_mask,rpt_tone,rpt_end,rpt_code} actual=%h expected=%h",
                     req, idx, act, exp);
        end
    endtask

    vec_t zero_v;

    initial begin
        zero_v = '0;
        idle_inputs();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 outputs quiet after reset
        zero_v.req = 4'd1;
        compare(1, -1, zero_v);

        drive(VECS[0]);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            compare(int'(VECS[i].req), i, VECS[i]);
            if (i + 1 < NV) drive(VECS[i+1]);
            else idle_inputs();
        end

        // R1 reset mid-run silences both sounding transmitters
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        compare(1, 100, zero_v);

        // R1 channel disabled again after reset: command ignored
        cmd_wr = 1'b1; cmd_ch = 1'b0; cmd_code = 6'h03;
        @(negedge clk);
        compare(1, 101, zero_v);
        cmd_wr = 1'b1; cmd_ch = 1'b1; cmd_code = 6'h09;
        @(negedge clk);
        compare(1, 102, zero_v);
        idle_inputs();
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule